// File: doc/BRIEF.md
# Left Shift Unit with Condition Flags

This block performs a left shift of an integer operand and produces the six condition flags of the classic two-operand integer instruction set. The operand can be 8, 16, 32 or 64 bits wide. Logical and arithmetic left shift give the same result, so there is only one mode. The caller presents a 64-bit operand, a two-bit size code, a raw 8-bit shift count and the current flag vector, and pulses the input valid. One clock later the block returns the result, masked to the selected width, together with the updated flag vector.

The raw count is first reduced to a masked count. The masking rule depends on the operand size. A masked count of zero acts as a no-op: the operand passes through and every flag is left exactly as it came in. Because a narrow operand can be shifted by more than its own width, the carry then comes from below bit 0 and is zero. The overflow flag has a defined value only for a shift by one. The adjust flag is never touched. Instruction decode, operand fetch, write-back and partial-register merging are handled elsewhere.

Top module: `shl_flags_unit`

## Requirements
- R1: The size code selects the width W: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Only operand bits below W take part. The result equals those bits shifted left by the masked count and truncated to W bits, and every result bit at or above W is zero.
- R2: For size codes 0, 1 and 2, the masked count is the low 5 bits of the raw count. For size code 3 it is the low 6 bits.
- R3: When the masked count is zero, the result is the width-masked operand and the output flag vector equals the input flag vector bit for bit.
- R4: For a nonzero masked count, CF is the bit that passed last through the top of the W-bit field, which is operand bit W minus count. When the count exceeds W, CF is 0.
- R5: For a masked count of exactly 1, OF is the XOR of the result MSB and the new CF. For masked counts above 1, OF keeps its input value.
- R6: For a nonzero masked count, SF is bit W-1 of the result, and ZF is 1 exactly when the W-bit result is zero. An 8-bit operand shifted by 8 or more, or a 16-bit operand shifted by 16 or more, gives zero with ZF set.
- R7: For a nonzero masked count, PF is 1 when the low byte of the result holds an even number of ones, whatever the size.
- R8: Flag vectors use bit 0 for CF, 1 for PF, 2 for AF, 3 for ZF, 4 for SF and 5 for OF. AF on the output always equals AF on the input.
- R9: The output valid is high exactly one clock after the input valid was high, and low otherwise. A synchronous reset clears it. The result and flags are registered on each accepted input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input operation valid |
| opnd | input | 64 | Operand to shift |
| size_sel | input | 2 | Operand size code (0:8, 1:16, 2:32, 3:64 bits) |
| raw_cnt | input | 8 | Unmasked shift count |
| flg_in | input | 6 | Incoming flags {OF,SF,ZF,AF,PF,CF} |
| out_vld | output | 1 | Result valid, one clock after in_vld |
| res_out | output | 64 | Shifted result, zero above the selected width |
| flg_out | output | 6 | Updated flags {OF,SF,ZF,AF,PF,CF} |

## Verification
The bench targets the following cases:
- Raw counts whose upper bits are set. A design that masked with the wrong width would shift an 8-bit operand by 35 rather than 3, or a 64-bit operand by 67 rather than 3.
- Raw counts such as 0x20 or 0x40 that mask to zero. A design that still wrote the flags in that case would change a flag vector of all ones.
- Narrow operands shifted by exactly their width and by more than their width. These show whether CF takes operand bit 0 in the first case and 0 in the second, and whether ZF is set.
- Shifts by one and shifts by more than one. These catch an overflow flag that is computed for every count instead of being kept, and a parity flag taken from the whole result instead of from its low byte.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int DATA_W         = 64;
  localparam int CNT_W          = 8;
  localparam int NUM_SIZES      = $clog2(DATA_W / 8) + 1;
  localparam int SIZE_W         = $clog2(NUM_SIZES);
  localparam int SHAMT_W        = $clog2(DATA_W);
  localparam int SMALL_CNT_BITS = 5;
  localparam int FLAG_W         = 6;

  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_AF = 2;
  localparam int FL_ZF = 3;
  localparam int FL_SF = 4;
  localparam int FL_OF = 5;

  // Ones below the selected operand width
  function automatic logic [DATA_W-1:0] lane_mask(logic [SIZE_W-1:0] sz);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < (8 << sz)) m[i] = 1'b1;
    return m;
  endfunction

  // 1 when the byte holds an even number of ones
  function automatic logic even_parity8(logic [7:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/shl_cnt_mask.sv
module shl_cnt_mask
  import shl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic [SIZE_W-1:0]  size_sel,
  input  logic [CW-1:0]      raw_cnt,
  output logic [SHAMT_W-1:0] mcnt,
  output logic               cnt_zero,
  output logic               cnt_one,
  output logic               cnt_over
);
  localparam int NS = $clog2(DW / 8) + 1;

  logic [SHAMT_W-1:0] cnt_lane  [NS];
  logic               over_lane [NS];
  logic               unused_cnt_hi;

  assign unused_cnt_hi = ^raw_cnt[CW-1:SHAMT_W];

  for (genvar s = 0; s < NS; s++) begin : g_size
    localparam int LANE_W = 8 << s;
    localparam int KEEP   = (LANE_W == DW) ? SHAMT_W : SMALL_CNT_BITS;
    if (KEEP == SHAMT_W) begin : g_full
      assign cnt_lane[s] = raw_cnt[SHAMT_W-1:0];
    end else begin : g_part
      assign cnt_lane[s] = {{(SHAMT_W-KEEP){1'b0}}, raw_cnt[KEEP-1:0]};
    end
    assign over_lane[s] = ({1'b0, cnt_lane[s]} > (SHAMT_W+1)'(LANE_W));
  end

  assign mcnt     = cnt_lane[size_sel];
  assign cnt_over = over_lane[size_sel];
  assign cnt_zero = (mcnt == '0);
  assign cnt_one  = (mcnt == SHAMT_W'(1));
endmodule

// File: rtl/shl_datapath.sv
module shl_datapath
  import shl_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0]      opnd,
  input  logic [SIZE_W-1:0]  size_sel,
  input  logic [SHAMT_W-1:0] mcnt,
  output logic [DW-1:0]      res,
  output logic               res_msb,
  output logic               carry_out
);
  localparam int NS = $clog2(DW / 8) + 1;

  logic [DW-1:0] mask_lane [NS];
  logic          msb_lane  [NS];
  logic          cf_lane   [NS];
  logic [DW-1:0] op_m;
  logic [DW:0]   wide;
  logic [DW-1:0] res_full;

  for (genvar s = 0; s < NS; s++) begin : g_lane
    localparam int LANE_W = 8 << s;
    if (LANE_W == DW) begin : g_top
      assign mask_lane[s] = '1;
    end else begin : g_narrow
      assign mask_lane[s] = {{(DW-LANE_W){1'b0}}, {LANE_W{1'b1}}};
    end
    // Bit that crossed the top of this lane last
    assign cf_lane[s]  = wide[LANE_W];
    assign msb_lane[s] = res_full[LANE_W-1];
  end

  assign op_m      = opnd & mask_lane[size_sel];
  assign wide      = {1'b0, op_m} << mcnt;
  assign res_full  = wide[DW-1:0] & mask_lane[size_sel];
  assign res       = res_full;
  assign res_msb   = msb_lane[size_sel];
  assign carry_out = cf_lane[size_sel];
endmodule

// File: rtl/shl_flag_gen.sv
module shl_flag_gen
  import shl_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0]     res,
  input  logic              res_msb,
  input  logic              carry_out,
  input  logic              cnt_zero,
  input  logic              cnt_one,
  input  logic [FLAG_W-1:0] flg_in,
  output logic [FLAG_W-1:0] flg_new
);
  always_comb begin
    flg_new = flg_in;
    if (!cnt_zero) begin
      flg_new[FL_CF] = carry_out;
      flg_new[FL_PF] = even_parity8(res[7:0]);
      flg_new[FL_ZF] = (res == '0);
      flg_new[FL_SF] = res_msb;
      if (cnt_one) flg_new[FL_OF] = res_msb ^ carry_out;
    end
  end
endmodule

// File: rtl/shl_flags_unit.sv
module shl_flags_unit
  import shl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DW-1:0]     opnd,
  input  logic [SIZE_W-1:0] size_sel,
  input  logic [CW-1:0]     raw_cnt,
  input  logic [FLAG_W-1:0] flg_in,
  output logic              out_vld,
  output logic [DW-1:0]     res_out,
  output logic [FLAG_W-1:0] flg_out
);
  logic [SHAMT_W-1:0] mcnt;
  logic               cnt_zero, cnt_one, cnt_over;
  logic [DW-1:0]      res_c;
  logic               res_msb, carry_out;
  logic [FLAG_W-1:0]  flg_c;

  shl_cnt_mask #(.DW(DW), .CW(CW)) u_cnt (
    .size_sel (size_sel),
    .raw_cnt  (raw_cnt),
    .mcnt     (mcnt),
    .cnt_zero (cnt_zero),
    .cnt_one  (cnt_one),
    .cnt_over (cnt_over)
  );

  shl_datapath #(.DW(DW)) u_dp (
    .opnd      (opnd),
    .size_sel  (size_sel),
    .mcnt      (mcnt),
    .res       (res_c),
    .res_msb   (res_msb),
    .carry_out (carry_out)
  );

  shl_flag_gen #(.DW(DW)) u_flg (
    .res       (res_c),
    .res_msb   (res_msb),
    .carry_out (carry_out),
    .cnt_zero  (cnt_zero),
    .cnt_one   (cnt_one),
    .flg_in    (flg_in),
    .flg_new   (flg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      res_out <= res_c;
      flg_out <= flg_c;
    end
  end

  assert_vld_rise_R9: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  assert_vld_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ((res_out & ~lane_mask($past(size_sel))) == '0));
  assert_zero_cnt_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && cnt_zero) |=> (flg_out == $past(flg_in)));
  assert_cf_beyond_R4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && cnt_over) |=> !flg_out[FL_CF]);
  assert_of_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !cnt_zero && !cnt_one) |=> (flg_out[FL_OF] == $past(flg_in[FL_OF])));
  assert_af_keep_R8: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> (flg_out[FL_AF] == $past(flg_in[FL_AF])));
endmodule

// File: tb/tb_shl_flags_unit.sv
`timescale 1ns/1ps
module tb_shl_flags_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [63:0] opnd = '0;
  logic [1:0]  size_sel = '0;
  logic [7:0]  raw_cnt = '0;
  logic [5:0]  flg_in = '0;
  logic        out_vld;
  logic [63:0] res_out;
  logic [5:0]  flg_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  shl_flags_unit dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .opnd(opnd), .size_sel(size_sel),
    .raw_cnt(raw_cnt), .flg_in(flg_in), .out_vld(out_vld), .res_out(res_out),
    .flg_out(flg_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bit-serial model: one position per step
  function automatic logic [69:0] model(logic [63:0] op, logic [1:0] sz,
                                        logic [7:0] rc, logic [5:0] fi);
    int          w;
    int          c;
    logic [63:0] m;
    logic [63:0] v;
    logic [5:0]  fo;
    logic        cf;
    int          ones;
    w  = 8 << sz;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    c  = (sz == 2'd3) ? int'(rc % 64) : int'(rc % 32);
    v  = op & m;
    fo = fi;
    cf = 1'b0;
    if (c == 0) return {fi, v};
    for (int i = 0; i < c; i++) begin
      cf = v[w-1];
      v  = (v << 1) & m;
    end
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(v[i]);
    fo[0] = cf;
    fo[1] = (ones % 2 == 0);
    fo[3] = (v == 64'd0);
    fo[4] = v[w-1];
    if (c == 1) fo[5] = v[w-1] ^ cf;
    return {fo, v};
  endfunction

  task automatic run_op(input logic [63:0] op, input logic [1:0] sz,
                        input logic [7:0] rc, input logic [5:0] fi);
    logic [69:0] e;
    int          c;
    e = model(op, sz, rc, fi);
    c = (sz == 2'd3) ? int'(rc % 64) : int'(rc % 32);
    @(negedge clk);
    opnd = op; size_sel = sz; raw_cnt = rc; flg_in = fi; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    chk("R9 out_vld after accept", 64'(out_vld), 64'd1);
    chk("R1 R2 result", res_out, e[63:0]);
    if (c == 0) begin
      chk("R3 flags pass on zero count", 64'(flg_out), 64'(fi));
    end else begin
      chk("R4 CF", 64'(flg_out[0]), 64'(e[64]));
      chk("R5 OF", 64'(flg_out[5]), 64'(e[69]));
      chk("R6 SF ZF", 64'(flg_out[4:3]), 64'(e[68:67]));
      chk("R7 PF", 64'(flg_out[1]), 64'(e[65]));
    end
    chk("R8 AF", 64'(flg_out[2]), 64'(fi[2]));
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] rop;
    logic [7:0]  rcnt;
    void'($urandom(32'd2468));
    repeat (3) @(negedge clk);
    chk("R9 out_vld in reset", 64'(out_vld), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 out_vld idle", 64'(out_vld), 64'd0);

    run_op(64'h42, 2'd0, 8'd1, 6'h00);            // 0x84, OF set
    run_op(64'h81, 2'd0, 8'd1, 6'h00);            // 0x02, CF and OF set
    run_op(64'hC0, 2'd0, 8'd1, 6'h20);            // OF cleared
    run_op(64'hFF11, 2'd0, 8'h23, 6'h00);         // R2: 35 -> 3
    run_op(64'h43, 2'd0, 8'd8, 6'h00);            // R6: zero, CF from bit 0
    run_op(64'hFF, 2'd0, 8'd9, 6'h01);            // R4: beyond width, CF 0
    run_op(64'h1234, 2'd1, 8'd16, 6'h00);         // R6: 16-bit to zero
    run_op(64'hFFFF, 2'd1, 8'd31, 6'h01);         // R4: beyond width
    run_op(64'h1, 2'd2, 8'h1F, 6'h00);            // 1 << 31
    run_op(64'h1234_5678, 2'd2, 8'h21, 6'h00);    // R2: 33 -> 1
    run_op(64'h1, 2'd3, 8'h43, 6'h00);            // R2: 67 -> 3
    run_op(64'h1, 2'd3, 8'h3F, 6'h00);            // 1 << 63
    run_op(64'hDEAD_BEEF_0000_0042, 2'd0, 8'h20, 6'h3F); // R3: masks to zero
    run_op(64'h42, 2'd3, 8'h40, 6'h3F);           // R3: 64-bit zero count
    run_op(64'h0000_0003, 2'd2, 8'd2, 6'h24);     // R7: low byte 0x0C, AF and OF kept
    run_op(64'h0000_0001, 2'd2, 8'd2, 6'h00);     // R7: odd parity

    for (int i = 0; i < 400; i++) begin
      rop  = {$urandom, $urandom};
      rcnt = (i % 3 == 0) ? 8'($urandom % 4) : 8'($urandom);
      run_op(rop, 2'($urandom), rcnt, 6'($urandom));
    end

    @(negedge clk);
    chk("R9 out_vld falls when idle", 64'(out_vld), 64'd0);
    in_vld = 1'b1; opnd = 64'h5; raw_cnt = 8'd1; size_sel = 2'd0;
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reset clears out_vld", 64'(out_vld), 64'd0);
    in_vld = 1'b0; rst = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule